// File: doc/BRIEF.md
# Parallel Radix-4 Booth Signed Multiplier

This block multiplies two two's-complement operands in a single combinational pass. The multiplier operand is recoded into radix-4 Booth digits. Each digit comes from an overlapping window of three bits and has a value from -2 to +2. Every digit selects a multiple of the multiplicand: zero, once, or twice, with or without negation. Each selected multiple is shifted left by two bit positions per group. All of these partial products are then added together to give the full-width signed product.

The block has no clock, no state and no handshake, so a new operand pair can be applied at any time. After the combinational delay, the product and a per-group digit vector reflect that pair. The digit vector is meant for debug and for checking the recoding.

Top module: `booth_r4_mul`

## Requirements
- R1: `product_o` equals the exact two's-complement product of `mcand_i` and `mplier_i` for every input pair. Its width is MCAND_W + MPLIER_W, and its bit 0 always equals the AND of the two operands' bit 0.
- R2: The most negative multiplicand times the most negative multiplier gives the positive value 2^(MCAND_W+MPLIER_W-2), with no overflow.
- R3: Group k reads the multiplier bits (a[2k+1], a[2k], a[2k-1]), where a[-1] is a zero appended below bit 0. The group's digit is a[2k-1] + a[2k] - 2*a[2k+1]. Read with a[2k+1] as the leftmost bit, the triples map as follows: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1.
- R4: `digit_o` holds the digit of group k at bits [3k+2:3k] as a 3-bit two's-complement value. Every digit lies in the range -2 to +2.
- R5: The multiplier is sign-extended by two bits above its top bit, giving MPLIER_W/2+1 groups. The topmost group's digit is always 0 for signed operands.
- R6: A zero multiplicand gives a zero product for any multiplier. A zero multiplier gives all-zero digits and a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | MCAND_W | Multiplicand, two's complement |
| mplier_i | input | MPLIER_W | Multiplier, two's complement, width even |
| product_o | output | MCAND_W+MPLIER_W | Signed product |
| digit_o | output | 3*(MPLIER_W/2+1) | Booth digit of each group, 3-bit signed, group 0 lowest |

## Verification
The assertions are immediate checks evaluated whenever the inputs settle. They assume the operands are fully driven, two-state values that are held stable long enough for the combinational sums to resolve. The bench meets this by changing the operands only on the rising clock edge and sampling the outputs on the falling edge. It applies the operands as raw bit patterns, so every code from 0 to 2^W-1 is covered, including the most negative value.

// File: rtl/booth_r4_pkg.sv
package booth_r4_pkg;
  // Booth digit: 3-bit two's complement, -2..+2
  typedef logic signed [2:0] bdigit_t;
endpackage

// File: rtl/booth_group_dec.sv
module booth_group_dec
  import booth_r4_pkg::*;
(
  input  logic [2:0] trip_i,   // {a[2k+1], a[2k], a[2k-1]}
  output bdigit_t    digit_o,
  output logic       one_o,
  output logic       dbl_o,
  output logic       neg_o
);
  always_comb begin
    one_o = 1'b0;
    dbl_o = 1'b0;
    neg_o = 1'b0;
    unique case (trip_i)
      3'b001, 3'b010: one_o = 1'b1;
      3'b011:         dbl_o = 1'b1;
      3'b100:         begin dbl_o = 1'b1; neg_o = 1'b1; end
      3'b101, 3'b110: begin one_o = 1'b1; neg_o = 1'b1; end
      default:        ;
    endcase
  end

  always_comb begin
    if (dbl_o)      digit_o = neg_o ? -3'sd2 : 3'sd2;
    else if (one_o) digit_o = neg_o ? -3'sd1 : 3'sd1;
    else            digit_o = 3'sd0;
  end

  always_comb begin
    assert_sel_onehot_R3: assert ($onehot0({one_o, dbl_o}))
      else $error("R3: one and double both selected");
    assert_neg_needs_sel_R3: assert (!neg_o || one_o || dbl_o)
      else $error("R3: negate without a magnitude");
    assert_digit_range_R4: assert (digit_o >= -3'sd2 && digit_o <= 3'sd2)
      else $error("R4: digit out of range");
  end
endmodule

// File: rtl/booth_pp_sel.sv
module booth_pp_sel #(
  parameter int MCAND_W = 8,
  parameter int PW      = 16,
  parameter int SHIFT   = 0
) (
  input  logic [MCAND_W-1:0] mcand_i,
  input  logic               one_i,
  input  logic               dbl_i,
  input  logic               neg_i,
  output logic [PW-1:0]      pp_o
);
  localparam int EXT_W = PW - MCAND_W;

  logic [PW-1:0] b_ext;
  logic [PW-1:0] mag;
  logic [PW-1:0] signed_mag;

  assign b_ext = {{EXT_W{mcand_i[MCAND_W-1]}}, mcand_i};

  always_comb begin
    if (dbl_i)      mag = b_ext << 1;
    else if (one_i) mag = b_ext;
    else            mag = '0;
    signed_mag = neg_i ? (~mag + PW'(1)) : mag;
    pp_o       = signed_mag << SHIFT;
  end

  always_comb begin
    assert_zero_pp_R6: assert (one_i || dbl_i || pp_o == '0)
      else $error("R6: zero digit left a nonzero partial product");
  end
endmodule

// File: rtl/booth_pp_sum.sv
module booth_pp_sum #(
  parameter int NGRP = 5,
  parameter int PW   = 16
) (
  input  logic [NGRP-1:0][PW-1:0] pp_i,
  output logic [PW-1:0]           sum_o
);
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NGRP; k++) begin
      sum_o = sum_o + pp_i[k];
    end
  end
endmodule

// File: rtl/booth_r4_mul.sv
module booth_r4_mul
  import booth_r4_pkg::*;
#(
  parameter int MCAND_W  = 8,
  parameter int MPLIER_W = 8,
  localparam int PW      = MCAND_W + MPLIER_W,
  localparam int NGRP    = MPLIER_W / 2 + 1
) (
  input  logic [MCAND_W-1:0]  mcand_i,
  input  logic [MPLIER_W-1:0] mplier_i,
  output logic [PW-1:0]       product_o,
  output logic [3*NGRP-1:0]   digit_o
);
  localparam int EXT_W = MPLIER_W + 3;

  logic [EXT_W-1:0]          a_ext;
  logic [NGRP-1:0][PW-1:0]   pp;
  logic [NGRP-1:0]           sel_one, sel_dbl, sel_neg;

  // two sign bits on top, a zero below bit 0
  assign a_ext = {mplier_i[MPLIER_W-1], mplier_i[MPLIER_W-1], mplier_i, 1'b0};

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    bdigit_t dig;

    booth_group_dec u_dec (
      .trip_i  (a_ext[2*k+2 -: 3]),
      .digit_o (dig),
      .one_o   (sel_one[k]),
      .dbl_o   (sel_dbl[k]),
      .neg_o   (sel_neg[k])
    );

    booth_pp_sel #(
      .MCAND_W (MCAND_W),
      .PW      (PW),
      .SHIFT   (2*k)
    ) u_sel (
      .mcand_i (mcand_i),
      .one_i   (sel_one[k]),
      .dbl_i   (sel_dbl[k]),
      .neg_i   (sel_neg[k]),
      .pp_o    (pp[k])
    );

    assign digit_o[3*k +: 3] = dig;
  end

  booth_pp_sum #(
    .NGRP (NGRP),
    .PW   (PW)
  ) u_sum (
    .pp_i  (pp),
    .sum_o (product_o)
  );

  always_comb begin
    assert_top_digit_zero_R5: assert (digit_o[3*NGRP-1 -: 3] == 3'b000)
      else $error("R5: top group digit not zero");
    assert_zero_mcand_R6: assert (mcand_i != '0 || product_o == '0)
      else $error("R6: zero multiplicand gave nonzero product");
    assert_zero_mplier_R6: assert (mplier_i != '0 || (digit_o == '0 && product_o == '0))
      else $error("R6: zero multiplier gave nonzero digits or product");
    assert_lsb_R1: assert (product_o[0] == (mcand_i[0] & mplier_i[0]))
      else $error("R1: product bit 0 wrong");
  end
endmodule

// File: tb/booth_r4_mul_tb.sv
`timescale 1ns / 1ps
module booth_r4_mul_tb;
  localparam int MCAND_W  = 8;
  localparam int MPLIER_W = 8;
  localparam int PW       = MCAND_W + MPLIER_W;
  localparam int NGRP     = MPLIER_W / 2 + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [MCAND_W-1:0]  mcand;
  logic [MPLIER_W-1:0] mplier;
  logic [PW-1:0]       product;
  logic [3*NGRP-1:0]   digits;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  booth_r4_mul #(.MCAND_W(MCAND_W), .MPLIER_W(MPLIER_W)) u_dut (
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .product_o (product),
    .digit_o   (digits)
  );

  function automatic int mbit(input logic [MPLIER_W-1:0] m, input int j);
    if (j < 0) return 0;
    if (j >= MPLIER_W) return int'(m[MPLIER_W-1]);
    return int'(m[j]);
  endfunction

  // apply at posedge, sample at following negedge
  task automatic apply_check(input logic [MCAND_W-1:0] b, input logic [MPLIER_W-1:0] a,
                             input string req);
    logic signed [PW-1:0] exp_p;
    @(posedge clk);
    mcand  = b;
    mplier = a;
    @(negedge clk);
    exp_p = $signed(b) * $signed(a);
    n_vec++;
    if (product !== exp_p) begin
      n_fail++;
      $display("FAIL %s b=%0d a=%0d product actual=%0d expected=%0d", req,
               $signed(b), $signed(a), $signed(product), exp_p);
    end
    for (int k = 0; k < NGRP; k++) begin
      int ed;
      ed = mbit(a, 2*k-1) + mbit(a, 2*k) - 2*mbit(a, 2*k+1);
      if (int'($signed(digits[3*k +: 3])) != ed) begin
        n_fail++;
        $display("FAIL R3/R4 a=%0h group %0d digit actual=%0d expected=%0d",
                 a, k, $signed(digits[3*k +: 3]), ed);
      end
    end
  endtask

  task automatic t_reset_state;  // R6: both zero
    apply_check('0, '0, "R6");
    if (digits !== '0) begin
      n_fail++;
      $display("FAIL R6 digits actual=%0h expected=0", digits);
    end
  endtask

  task automatic t_corners;  // R2, R5, R6
    apply_check({1'b1, {(MCAND_W-1){1'b0}}}, {1'b1, {(MPLIER_W-1){1'b0}}}, "R2");
    if (product !== PW'(1) << (PW-2)) begin
      n_fail++;
      $display("FAIL R2 product actual=%0h expected=%0h", product, PW'(1) << (PW-2));
    end
    apply_check('0, 8'h5A, "R6");
    apply_check(8'h7F, '0, "R6");
    apply_check(8'hFF, 8'hFF, "R1");
    apply_check(8'h7F, 8'h80, "R1");
    if (digits[3*NGRP-1 -: 3] !== 3'b000) begin
      n_fail++;
      $display("FAIL R5 top digit actual=%0h expected=0", digits[3*NGRP-1 -: 3]);
    end
  endtask

  task automatic t_digit_table;  // R3: every triple in group 1 via bits 3..1
    for (int t = 0; t < 8; t++) begin
      apply_check(8'h03, MPLIER_W'(t << 1), "R3");
    end
  endtask

  task automatic t_exhaustive;  // R1, R4
    for (int i = 0; i < (1 << MPLIER_W); i++) begin
      for (int j = 0; j < (1 << MCAND_W); j++) begin
        apply_check(MCAND_W'(j), MPLIER_W'(i), "R1");
      end
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    mcand  = '0;
    mplier = '0;
    t_reset_state();
    t_corners();
    t_digit_table();
    t_exhaustive();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule